// File: doc/BRIEF.md
# Strip Readout Frame Capture

This block sits in the 40 MHz system clock domain behind the ADC that digitises the shared analogue output of two daisy-chained strip front-end chips. The first chip in the chain sends its frame before the last chip. Each chip raises its own data-valid strobe while its frame is on the line, and every clock carries one time slot. A frame has 16 header slots and then 128 channel slots. The block counts the slots, drops the header and sign-extends each 10-bit channel code to a 16-bit word. It then builds one event record: the first chip's 128 words, the last chip's 128 words, and a 32-bit timestamp split into two words.

Words go into an internal FIFO on a provisional basis. The reader sees them only once the whole event is complete, and a one-cycle done pulse marks that moment. When an event is cut short, or runs out of room, the block rolls the FIFO write position back to the last complete event. The reader therefore never sees a partial record. Reads use a show-ahead port: the head word is on `rd_word` whenever `rd_avail` is high, and `rd_en` pops it.

Top module: `strip_frame_capture`

## Requirements
- R1: After reset, `rd_avail`, `evt_done`, `ovf_flag` and `frame_err` are all low.
- R2: A complete event appears in the FIFO as 258 words in this order: the first chip's channels 0 to 127, the last chip's channels 0 to 127, timestamp bits 31:16, then timestamp bits 15:0.
- R3: The first 16 slots of each frame (counted from the first cycle the chip's strobe is high) are never stored. Each complete event adds exactly 258 words.
- R4: A channel code is a 10-bit two's-complement value with bit 9 as the sign. It is stored as that value sign-extended to 16 bits, for example 0x1FF→0x01FF, 0x200→0xFE00 and 0x3FF→0xFFFF.
- R5: No word of an event is readable before the event is complete. `evt_done` pulses for one cycle, and in that same cycle the event's words first become readable. `evt_done`, `ovf_flag` and `frame_err` are never high together.
- R6: The timestamp stored with an event is the value of `stamp` in the cycle of the first chip's first slot. Later changes to `stamp` have no effect on that event.
- R7: If a chip's strobe falls before 144 slots of its frame have been seen, `frame_err` pulses once. No word of that event becomes readable, and the block again waits for the first chip.
- R8: If the event needs to write a word while 512 words are stored, `ovf_flag` pulses once. The partial event is removed and its remaining slots are dropped, so no `evt_done` is raised for it. Events completed earlier stay intact and in order.
- R9: While the block waits for the first chip, a frame on the last chip's strobe writes nothing and raises no flag.
- R10: While `rd_avail` is high and `rd_en` is low, `rd_word` and `rd_avail` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| dv_first | input | 1 | Data-valid strobe of the first chip in the chain |
| dv_last | input | 1 | Data-valid strobe of the last chip in the chain |
| adc_code | input | 10 | ADC sample for the current slot, two's complement |
| stamp | input | 32 | Per-event timestamp, sampled at the first slot of the event |
| rd_en | input | 1 | Pop the head word of the FIFO |
| rd_word | output | 16 | Head word of the FIFO (show-ahead) |
| rd_avail | output | 1 | At least one word of a complete event is readable |
| evt_done | output | 1 | One-cycle pulse when an event is committed |
| ovf_flag | output | 1 | One-cycle pulse when an event is dropped for lack of space |
| frame_err | output | 1 | One-cycle pulse when a frame ends early |

## Verification
A slot counter that is off by one shifts the whole record by one word. It also either stores one header slot or drops channel 127. The scoreboard would then report this as a mismatch on the first word read after `evt_done`. A wrong commit or rollback pointer shows up as leftover or missing words once the FIFO is drained, or as `rd_avail` rising mid-event. The visibility check catches this within the event's own 290 cycles. A phase machine stuck on the wrong chip appears as a missing `evt_done` or as stray `frame_err` pulses, which the pulse counts catch a few cycles after the stimulus ends.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int SFC_HDR_SLOTS  = 16;
    localparam int SFC_CHAN_SLOTS = 128;
    localparam int SFC_ADC_W      = 10;
    localparam int SFC_WORD_W     = 16;
    localparam int SFC_STAMP_W    = 32;
    localparam int SFC_FIFO_AW    = 9;

    // Event phases: first chip frame, wait, last chip frame, two stamp words
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_FRAME_A  = 3'd1,
        PH_WAIT_B   = 3'd2,
        PH_FRAME_B  = 3'd3,
        PH_STAMP_HI = 3'd4,
        PH_STAMP_LO = 3'd5
    } phase_e;

    // Control handed from the parser to the FIFO each cycle
    typedef struct packed {
        logic wr;
        logic commit;
        logic abort;
    } fifo_ctl_t;

endpackage

// File: rtl/sfc_frame_parser.sv
module sfc_frame_parser
    import sfc_pkg::*;
#(
    parameter int HDR_SLOTS  = SFC_HDR_SLOTS,
    parameter int CHAN_SLOTS = SFC_CHAN_SLOTS,
    parameter int ADC_W      = SFC_ADC_W,
    parameter int WORD_W     = SFC_WORD_W,
    parameter int STAMP_W    = SFC_STAMP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dv_first,
    input  logic               dv_last,
    input  logic [ADC_W-1:0]   adc_code,
    input  logic [STAMP_W-1:0] stamp,
    input  logic               fifo_full,
    output fifo_ctl_t          ctl,
    output logic [WORD_W-1:0]  wr_word,
    output logic               done_q,
    output logic               ovf_q,
    output logic               err_q
);

    localparam int SLOTS = HDR_SLOTS + CHAN_SLOTS;
    localparam int CNT_W = $clog2(SLOTS);
    localparam int EXT_W = WORD_W - ADC_W;

    phase_e             phase;
    logic [CNT_W-1:0]   slot_cnt;
    logic [STAMP_W-1:0] stamp_q;
    logic               dropping;

    logic in_frame, cur_dv, want, ovf_now, short_now, last_slot;
    logic [WORD_W-1:0] chan_word;

    always_comb begin
        in_frame  = (phase == PH_FRAME_A) || (phase == PH_FRAME_B);
        cur_dv    = (phase == PH_FRAME_A) ? dv_first : dv_last;
        last_slot = (slot_cnt == CNT_W'(SLOTS - 1));
        chan_word = {{EXT_W{adc_code[ADC_W-1]}}, adc_code};
        want      = (in_frame && cur_dv && (slot_cnt >= CNT_W'(HDR_SLOTS)))
                 || (phase == PH_STAMP_HI) || (phase == PH_STAMP_LO);
        ovf_now   = want && !dropping && fifo_full;
        short_now = in_frame && !cur_dv;
        unique case (phase)
            PH_STAMP_HI: wr_word = stamp_q[STAMP_W-1 -: WORD_W];
            PH_STAMP_LO: wr_word = stamp_q[WORD_W-1:0];
            default:     wr_word = chan_word;
        endcase
        ctl.wr     = want && !dropping && !fifo_full;
        ctl.commit = (phase == PH_STAMP_LO) && !dropping && !fifo_full;
        ctl.abort  = ovf_now || short_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            slot_cnt <= '0;
            stamp_q  <= '0;
            dropping <= 1'b0;
            done_q   <= 1'b0;
            ovf_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= ctl.commit;
            ovf_q  <= ovf_now;
            err_q  <= short_now;
            unique case (phase)
                PH_IDLE: begin
                    if (dv_first) begin
                        stamp_q  <= stamp;
                        slot_cnt <= CNT_W'(1);
                        dropping <= 1'b0;
                        phase    <= PH_FRAME_A;
                    end
                end
                PH_FRAME_A: begin
                    if (!dv_first)     phase <= PH_IDLE;
                    else if (last_slot) phase <= PH_WAIT_B;
                    else               slot_cnt <= slot_cnt + 1'b1;
                end
                PH_WAIT_B: begin
                    if (dv_last) begin
                        slot_cnt <= CNT_W'(1);
                        phase    <= PH_FRAME_B;
                    end
                end
                PH_FRAME_B: begin
                    if (!dv_last)      phase <= PH_IDLE;
                    else if (last_slot) phase <= PH_STAMP_HI;
                    else               slot_cnt <= slot_cnt + 1'b1;
                end
                PH_STAMP_HI: phase <= PH_STAMP_LO;
                PH_STAMP_LO: phase <= PH_IDLE;
                default:     phase <= PH_IDLE;
            endcase
            if (ovf_now) dropping <= 1'b1;
        end
    end

endmodule

// File: rtl/sfc_event_fifo.sv
module sfc_event_fifo
    import sfc_pkg::*;
#(
    parameter int WORD_W = SFC_WORD_W,
    parameter int AW     = SFC_FIFO_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  fifo_ctl_t         ctl,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_avail,
    output logic              full
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, cm_ptr, rd_ptr;
    logic [PW-1:0]     wr_next;

    always_comb begin
        wr_next  = wr_ptr + 1'b1;
        full     = ((wr_ptr - rd_ptr) == PW'(DEPTH));
        rd_avail = (cm_ptr != rd_ptr);
        rd_word  = mem[rd_ptr[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (ctl.wr) mem[wr_ptr[AW-1:0]] <= wr_word;
    end

    // Speculative write pointer, committed pointer, read pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (ctl.abort)   wr_ptr <= cm_ptr;
            else if (ctl.wr) wr_ptr <= wr_next;
            if (ctl.commit)  cm_ptr <= ctl.wr ? wr_next : wr_ptr;
            if (rd_en && rd_avail) rd_ptr <= rd_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/strip_frame_capture.sv
module strip_frame_capture
    import sfc_pkg::*;
#(
    parameter int HDR_SLOTS  = SFC_HDR_SLOTS,
    parameter int CHAN_SLOTS = SFC_CHAN_SLOTS,
    parameter int ADC_W      = SFC_ADC_W,
    parameter int WORD_W     = SFC_WORD_W,
    parameter int STAMP_W    = SFC_STAMP_W,
    parameter int FIFO_AW    = SFC_FIFO_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dv_first,
    input  logic               dv_last,
    input  logic [ADC_W-1:0]   adc_code,
    input  logic [STAMP_W-1:0] stamp,
    input  logic               rd_en,
    output logic [WORD_W-1:0]  rd_word,
    output logic               rd_avail,
    output logic               evt_done,
    output logic               ovf_flag,
    output logic               frame_err
);

    fifo_ctl_t         ctl;
    logic [WORD_W-1:0] wr_word;
    logic              fifo_full;

    sfc_frame_parser #(
        .HDR_SLOTS (HDR_SLOTS),
        .CHAN_SLOTS(CHAN_SLOTS),
        .ADC_W     (ADC_W),
        .WORD_W    (WORD_W),
        .STAMP_W   (STAMP_W)
    ) i_parser (
        .clk      (clk),
        .rst      (rst),
        .dv_first (dv_first),
        .dv_last  (dv_last),
        .adc_code (adc_code),
        .stamp    (stamp),
        .fifo_full(fifo_full),
        .ctl      (ctl),
        .wr_word  (wr_word),
        .done_q   (evt_done),
        .ovf_q    (ovf_flag),
        .err_q    (frame_err)
    );

    sfc_event_fifo #(
        .WORD_W(WORD_W),
        .AW    (FIFO_AW)
    ) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .rd_avail(rd_avail),
        .full    (fifo_full)
    );

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dv_first,
    input logic              dv_last,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_word,
    input logic              rd_avail,
    input logic              evt_done,
    input logic              ovf_flag,
    input logic              frame_err,
    input logic              wr_en,
    input logic              full
);

    // R5: flags never coincide
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_done, ovf_flag, frame_err}));

    // R5: data becomes readable only with a done pulse
    a_r5_visible_on_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_avail) |-> evt_done);

    // R7: an early-end pulse follows a low strobe
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> ($past(!dv_first) || $past(!dv_last)));

    // R8: the parser never writes into a full FIFO
    a_r8_no_write_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R8: one overflow pulse per dropped event
    a_r8_ovf_single: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> !ovf_flag);

    // R10: head word holds while not popped
    a_r10_head_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_avail && !rd_en) |=> (rd_avail && $stable(rd_word)));

endmodule

bind strip_frame_capture sfc_checker #(.WORD_W(WORD_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .dv_first (dv_first),
    .dv_last  (dv_last),
    .rd_en    (rd_en),
    .rd_word  (rd_word),
    .rd_avail (rd_avail),
    .evt_done (evt_done),
    .ovf_flag (ovf_flag),
    .frame_err(frame_err),
    .wr_en    (ctl.wr),
    .full     (fifo_full)
);

// File: tb/test_strip_frame_capture.sv
module test_strip_frame_capture;

    localparam int CLK_PERIOD = 10;
    localparam int HDR   = 16;
    localparam int CHAN  = 128;
    localparam int SLOTS = HDR + CHAN;
    localparam int EVW   = 2 * CHAN + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dv_first = 1'b0;
    logic        dv_last = 1'b0;
    logic [9:0]  adc_code = '0;
    logic [31:0] stamp = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_word;
    logic        rd_avail, evt_done, ovf_flag, frame_err;

    strip_frame_capture i_strip_frame_capture (
        .clk(clk), .rst(rst), .dv_first(dv_first), .dv_last(dv_last),
        .adc_code(adc_code), .stamp(stamp), .rd_en(rd_en),
        .rd_word(rd_word), .rd_avail(rd_avail), .evt_done(evt_done),
        .ovf_flag(ovf_flag), .frame_err(frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, bad = 0;
    int n_done = 0, n_ovf = 0, n_err = 0, n_read = 0;
    bit reader_on = 1'b0;
    bit finished = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [9:0] chan_code(input int base, input int ch);
        case (ch)
            0: return 10'h1FF;
            1: return 10'h200;
            2: return 10'h3FF;
            3: return 10'h000;
            default: return 10'((base + ch * 37) % 1024);
        endcase
    endfunction

    function automatic logic [15:0] sx(input logic [9:0] c);
        return {{6{c[9]}}, c};
    endfunction

    // Scoreboard monitor: pops words and compares, counts flag pulses
    always @(negedge clk) begin
        if (rst) begin
            rd_en = 1'b0;
        end else begin
            if (evt_done)  n_done++;
            if (ovf_flag)  n_ovf++;
            if (frame_err) n_err++;
            if (reader_on && rd_avail) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected word", rd_word, 0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rd_word == e, t, "event word", rd_word, e);
                end
                n_read++;
                rd_en = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end
    end

    // Drives one frame; the first chip's frame flips stamp after slot 0 (R6)
    task automatic drive_frame(input bit last, input int base, input int nslots,
                               input bit keep);
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk);
            if (last) dv_last = 1'b1; else dv_first = 1'b1;
            if (!last && s == 1) stamp = ~stamp;
            if (s < HDR) begin
                adc_code = 10'h155 ^ 10'(s);
            end else begin
                adc_code = chan_code(base, s - HDR);
                if (keep) begin
                    exp_q.push_back(sx(adc_code));
                    tag_q.push_back("R2/R3/R4");
                end
            end
        end
        @(negedge clk);
        dv_first = 1'b0;
        dv_last  = 1'b0;
    endtask

    task automatic push_stamp(input logic [31:0] ts);
        exp_q.push_back(ts[31:16]); tag_q.push_back("R2/R6");
        exp_q.push_back(ts[15:0]);  tag_q.push_back("R2/R6");
    endtask

    task automatic send_event(input logic [31:0] ts, input int ba, input int bb,
                              input int gap, input bit keep);
        stamp = ts;
        drive_frame(1'b0, ba, SLOTS, keep);
        repeat (gap) @(negedge clk);
        drive_frame(1'b1, bb, SLOTS, keep);
        if (keep) push_stamp(ts);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d0, e0, o0, r0;
        logic [15:0] head;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_avail == 0, "R1", "rd_avail after reset", rd_avail, 0);
        check({evt_done, ovf_flag, frame_err} == 0, "R1", "flags after reset",
              {evt_done, ovf_flag, frame_err}, 0);

        // R5 / R10: visibility only at commit, head holds while not read
        stamp = 32'h1234_5678;
        drive_frame(1'b0, 11, SLOTS, 1'b1);
        check(rd_avail == 0, "R5", "avail after first frame", rd_avail, 0);
        repeat (3) @(negedge clk);
        drive_frame(1'b1, 500, SLOTS, 1'b1);
        push_stamp(32'h1234_5678);
        check(rd_avail == 0, "R5", "avail before stamp words", rd_avail, 0);
        @(negedge clk);
        check(rd_avail == 0 && evt_done == 0, "R5", "avail during stamp",
              rd_avail, 0);
        @(negedge clk);
        check(evt_done == 1 && rd_avail == 1, "R5", "done with avail",
              {evt_done, rd_avail}, 2'b11);
        head = rd_word;
        check(head == exp_q[0], "R10", "head word", head, exp_q[0]);
        repeat (3) @(negedge clk);
        check(rd_word == head && rd_avail, "R10", "head held", rd_word, head);
        r0 = n_read;
        reader_on = 1'b1;
        repeat (300) @(negedge clk);
        check(n_read - r0 == EVW, "R3", "words per event", n_read - r0, EVW);

        // R2/R4: more patterns, various gaps
        send_event(32'hCAFE_0001, 901, 3, 0, 1'b1);
        send_event(32'h8000_FFFF, 77, 1023, 25, 1'b1);
        repeat (300) @(negedge clk);
        check(n_done == 3, "R5", "done count", n_done, 3);
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

        // R7: early ends in either frame
        d0 = n_done; e0 = n_err; r0 = n_read;
        stamp = 32'h0BAD_0001;
        drive_frame(1'b0, 5, 5, 1'b0);
        repeat (3) @(negedge clk);
        drive_frame(1'b0, 5, 100, 1'b0);
        repeat (3) @(negedge clk);
        drive_frame(1'b0, 5, SLOTS, 1'b0);
        drive_frame(1'b1, 6, SLOTS - 1, 1'b0);
        repeat (10) @(negedge clk);
        check(n_err - e0 == 3, "R7", "early-end pulses", n_err - e0, 3);
        check(n_done == d0 && n_read == r0, "R7", "nothing stored",
              n_read - r0, 0);
        send_event(32'h0000_7777, 300, 301, 2, 1'b1);
        repeat (300) @(negedge clk);
        check(n_done == d0 + 1, "R7", "recovery event", n_done, d0 + 1);

        // R9: last chip frame while idle is ignored
        d0 = n_done; e0 = n_err; r0 = n_read;
        drive_frame(1'b1, 44, SLOTS, 1'b0);
        repeat (10) @(negedge clk);
        check(n_done == d0 && n_err == e0, "R9", "no flag", n_done - d0, 0);
        check(n_read == r0 && rd_avail == 0, "R9", "no words", n_read - r0, 0);

        // R8: overflow drops second event, first intact
        reader_on = 1'b0;
        repeat (3) @(negedge clk);
        d0 = n_done; o0 = n_ovf; r0 = n_read;
        send_event(32'hAAAA_5555, 123, 456, 1, 1'b1);
        send_event(32'h5555_AAAA, 789, 10, 1, 1'b0);
        check(n_ovf - o0 == 1, "R8", "overflow pulses", n_ovf - o0, 1);
        check(n_done - d0 == 1, "R8", "done count", n_done - d0, 1);
        reader_on = 1'b1;
        repeat (300) @(negedge clk);
        check(n_read - r0 == EVW, "R8", "kept words", n_read - r0, EVW);
        send_event(32'h0F0F_F0F0, 222, 333, 0, 1'b1);
        repeat (300) @(negedge clk);
        check(n_done - d0 == 2, "R8", "after overflow", n_done - d0, 2);
        check(exp_q.size() == 0, "R2", "final drain", exp_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule